// File: doc/BRIEF.md
# Prioritized Serial-Port Interrupt Encoder

This block is the interrupt-status logic of a serial controller. It receives four level-sensitive requests: receive condition, receive FIFO, transmit FIFO and modem status. A host can mask each request through an enable register. The block reports the most urgent unmasked request in a read-only status byte and drives an interrupt pin.

The status byte holds a 2-bit vector and an active-low pending flag. When nothing is pending it reads 0x01. The byte is refreshed on every clock. A request of higher rank that arrives after a lower one therefore replaces the reported vector at the next read.

The host writes to the status address only to set a 2-bit bank pointer. The block accepts no other write into that byte.

Top module: `uart_irq_prio`

## Requirements
- R1: After synchronous reset the enable register reads 0x00, the status register reads 0x01 and `irq` is low. Read data is registered: `rdata` shows the addressed register as it was just before the rising edge on which `rd` was high. Any other address reads 0x00.
- R2: A write to `ADDR_ENA` stores `wdata[3:0]` in the enable register. The bit map is: bit 3 enables modem, bit 2 enables receive, bit 1 enables transmit FIFO and bit 0 enables receive FIFO. Bits 7:4 of the enable register read zero.
- R3: A request counts as pending only while its input is high and its enable bit is 1.
- R4: Status bits 2:1 carry the vector of the highest-ranked pending request. Receive is 11 and ranks highest. Receive FIFO is 10 and ranks second. Transmit FIFO is 01 and ranks third. Modem is 00 and ranks lowest.
- R5: Status bit 0 is 0 when at least one request is pending and 1 when none is. When none is pending the vector is 00.
- R6: `irq` is high exactly when at least one enabled request is pending. It follows the request inputs combinationally in the same cycle.
- R7: A write to `ADDR_STAT` loads `wdata[6:5]` into status bits 6:5, the bank pointer. It changes no other status bit and does not change the enable register.
- R8: Status bits 7, 4 and 3 always read zero.
- R9: The vector and the pending flag are registered from the current requests on every rising edge. A read therefore reports the request state from one cycle before the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Host write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| req_rx | input | 1 | Receive-condition request |
| req_rxf | input | 1 | Receive-FIFO request |
| req_txf | input | 1 | Transmit-FIFO request |
| req_mdm | input | 1 | Modem-status request |
| irq | output | 1 | Active-high interrupt pin |

## Verification
The bench builds the block with its default addresses: the enable register at 1 and the status register at 2. With four sources and four enable bits there are only 256 mask-and-request pairs, so the bench sweeps all of them. For every pair it checks both `irq` and the full status byte. The small size also allows directed checks of the one-cycle refresh lag and of a higher-ranked request overtaking a lower one. A further check confirms that a status write carries bank bits through and has no effect on the enable register.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter logic [2:0] ADDR_ENA  = 3'd1,
  parameter logic [2:0] ADDR_STAT = 3'd2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata,
  input  logic       req_rx,
  input  logic       req_rxf,
  input  logic       req_txf,
  input  logic       req_mdm,
  output logic       irq
);

  logic [3:0] en_q;
  logic [1:0] bank_q;
  logic [1:0] vec_q;
  logic       pend_n_q;
  logic [7:0] rdata_q;
  logic [1:0] vec_d;
  logic       unused_wbits;

  wire act_rx  = req_rx  & en_q[2];
  wire act_rxf = req_rxf & en_q[0];
  wire act_txf = req_txf & en_q[1];
  wire act_mdm = req_mdm & en_q[3];
  wire any_act = act_rx | act_rxf | act_txf | act_mdm;

  wire wr_ena  = wr && (addr == ADDR_ENA);
  wire wr_stat = wr && (addr == ADDR_STAT);

  assign unused_wbits = wdata[7] ^ wdata[4];

  always_comb begin
    if (act_rx)       vec_d = 2'b11;
    else if (act_rxf) vec_d = 2'b10;
    else if (act_txf) vec_d = 2'b01;
    else              vec_d = 2'b00;
  end

  wire [7:0] stat_word = {1'b0, bank_q, 2'b00, vec_q, pend_n_q};
  wire [7:0] ena_word  = {4'b0000, en_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 4'h0;
      bank_q   <= 2'b00;
      vec_q    <= 2'b00;
      pend_n_q <= 1'b1;
      rdata_q  <= 8'h00;
    end else begin
      vec_q    <= vec_d;
      pend_n_q <= ~any_act;
      if (wr_ena)  en_q   <= wdata[3:0];
      if (wr_stat) bank_q <= wdata[6:5];
      if (rd) begin
        if (addr == ADDR_ENA)       rdata_q <= ena_word;
        else if (addr == ADDR_STAT) rdata_q <= stat_word;
        else                        rdata_q <= 8'h00;
      end
    end
  end

  assign rdata = rdata_q;
  assign irq   = any_act;

  p_en_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ena |=> en_q == $past(wdata[3:0]));

  p_rx_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (req_rx && en_q[2]) |=> vec_q == 2'b11);

  p_idle_vec_r5: assert property (@(posedge clk) disable iff (rst)
    pend_n_q |-> vec_q == 2'b00);

  p_pin_tracks_flag_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pend_n_q == !$past(irq));

  p_bank_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |=> $stable(bank_q));

  p_en_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_ena |=> $stable(en_q));

  p_masked_r3: assert property (@(posedge clk) disable iff (rst)
    (en_q == 4'h0) |-> !irq);

endmodule

// File: tb/test_uart_irq_prio.sv
module test_uart_irq_prio;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic req_rx = 1'b0, req_rxf = 1'b0, req_txf = 1'b0, req_mdm = 1'b0;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_ENA = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;

  always #2.5 clk = ~clk;

  uart_irq_prio i_uart_irq_prio (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .req_rx(req_rx), .req_rxf(req_rxf), .req_txf(req_txf),
    .req_mdm(req_mdm), .irq(irq));

  function automatic logic [7:0] exp_stat(input logic [3:0] e, input logic [3:0] r,
                                          input logic [1:0] b);
    logic [3:0] a;
    logic [1:0] v;
    a = e & r;
    if (a[2])      v = 2'b11;
    else if (a[0]) v = 2'b10;
    else if (a[1]) v = 2'b01;
    else           v = 2'b00;
    return {1'b0, b, 2'b00, v, (a == 4'h0)};
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic set_req(input logic [3:0] r);
    req_mdm = r[3]; req_rx = r[2]; req_txf = r[1]; req_rxf = r[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check8("R1 irq", {7'd0, irq}, 8'h00);
    rd_reg(A_ENA, d);  check8("R1 enable", d, 8'h00);
    rd_reg(A_STAT, d); check8("R1 status", d, 8'h01);
    rd_reg(3'd5, d);   check8("R1 other addr", d, 8'h00);

    // R2 upper bits drop
    wr_reg(A_ENA, 8'hF5);
    rd_reg(A_ENA, d); check8("R2 enable readback", d, 8'h05);

    // R3 R4 R5 R6 R8 exhaustive sweep
    for (int e = 0; e < 16; e++) begin
      wr_reg(A_ENA, 8'(e));
      rd_reg(A_ENA, d); check8("R2 enable map", d, 8'(e));
      for (int r = 0; r < 16; r++) begin
        @(negedge clk);
        set_req(4'(r));
        #1;
        check8("R6 irq", {7'd0, irq}, {7'd0, ((4'(e) & 4'(r)) != 4'h0)});
        @(negedge clk);
        rd_reg(A_STAT, d);
        check8("R4 R3 R5 R8 status", d, exp_stat(4'(e), 4'(r), 2'b00));
      end
    end

    // R9 one-cycle lag and overtaking
    wr_reg(A_ENA, 8'h0F);
    set_req(4'b0001);
    repeat (2) @(negedge clk);
    rd_reg(A_STAT, d); check8("R9 rxf first", d, 8'h04);
    addr = A_STAT; rd = 1'b1;
    set_req(4'b0101);
    @(negedge clk);
    rd = 1'b0;
    check8("R9 lag", rdata, 8'h04);
    rd_reg(A_STAT, d); check8("R9 rx overtakes", d, 8'h06);
    set_req(4'b0000);
    @(negedge clk);

    // R7 bank pointer only
    wr_reg(A_STAT, 8'hFF);
    rd_reg(A_STAT, d); check8("R7 bank set", d, 8'h61);
    rd_reg(A_ENA, d);  check8("R7 enable kept", d, 8'h0F);
    wr_reg(A_STAT, 8'hBE);
    rd_reg(A_STAT, d); check8("R7 bank 01", d, 8'h21);
    set_req(4'b1000);
    repeat (2) @(negedge clk);
    rd_reg(A_STAT, d); check8("R7 R4 modem with bank", d, 8'h20);
    set_req(4'b0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule